// File: doc/BRIEF.md
# System Control and Status Port

This block is an 8-bit control and status register on a simple I/O bus. It sits at one I/O address, 0x61 by default, and is reached with a chip select, an address, and separate read and write strobes. The four low bits hold software enables: the gate of interval timer channel 2, the speaker data enable, the parity-check enable and the channel-check enable. The four high bits report live and latched system status.

Inside, a small bus state machine turns each write strobe into a single commit pulse. Its states are `BUS_IDLE`, `BUS_WRITE` and `BUS_READ`. The transitions are:
- `BUS_IDLE`→`BUS_WRITE` on a decoded write. This transition fires the commit.
- `BUS_IDLE`→`BUS_READ` on a decoded read with no write.
- `BUS_WRITE`→`BUS_IDLE` when the write strobe falls.
- `BUS_READ`→`BUS_IDLE` when the read strobe falls.

Two sticky error latches hold parity and channel faults while they are enabled. A toggle flip-flop flips on each refresh request. The block drives the speaker, the timer gate and an NMI request toward the rest of the system.

Top module: `sysctl_port`

## Requirements
- R1: A write takes effect, and a read returns data, only when `io_cs` is 1 and `io_addr` equals 0x61. Otherwise `io_rdata` is 0x00 and no stored bit changes.
- R2: A write stores `io_wdata[3:0]` at the clock edge where the decoded write strobe is first seen. `io_wdata[7:4]` is ignored. A read returns the stored bits in `io_rdata[3:0]` (bit0 timer gate, bit1 speaker enable, bit2 parity enable, bit3 channel enable).
- R3: Only the first cycle of a held write strobe commits. A data change while the strobe stays high has no effect.
- R4: `io_rdata[5]` is the live `tmr2_out_i` level. `spkr_o` is `tmr2_out_i` AND stored bit1. `tmr2_gate_o` equals stored bit0.
- R5: `io_rdata[4]` is a flip-flop that inverts once per rising edge of `refresh_req_i`, however long the request is held.
- R6: `io_rdata[7]` becomes 1 at a clock edge where `parity_err_i` is 1 and the parity enable is 1. It stays 1 after the input falls. It never sets while the enable is 0.
- R7: `io_rdata[6]` behaves like R6, but with `chan_err_i` and the channel enable.
- R8: Writing an enable to 0 clears its error latch at the commit edge, even when the error input is 1 in that same cycle. Writing it to 1 while the error is present sets the latch at that same edge.
- R9: `nmi_req_o` is 1 exactly when either error latch is 1.
- R10: Reset clears the stored enables, both error latches and the refresh toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_cs | input | 1 | Chip select |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0 when not selected for read |
| tmr2_out_i | input | 1 | Timer channel 2 output level |
| refresh_req_i | input | 1 | Refresh request |
| parity_err_i | input | 1 | Memory parity error |
| chan_err_i | input | 1 | I/O channel error |
| tmr2_gate_o | output | 1 | Timer channel 2 gate |
| spkr_o | output | 1 | Speaker drive |
| nmi_req_o | output | 1 | NMI request |

## Verification
A register write that changes an enable can land in the same cycle as the error input that the enable guards. The bench provokes this by raising `parity_err_i` and `chan_err_i` on the very cycle the write strobe commits. It does this once with enables written to 0, where the clear must win and both status bits read 0. It does this once with the parity enable written to 1, where bit7 must read 1 and bit6 must stay 0. The expected bytes come from the bench's own model of the enables, the latches and the toggle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2
    } bus_state_e;

    localparam int DATA_W   = 8;
    localparam int EN_W     = 4;
    localparam int N_ERR    = 2;

    // enable bit positions
    localparam int B_GATE   = 0;
    localparam int B_SPKR   = 1;
    localparam int B_PAR_EN = 2;
    localparam int B_CHK_EN = 3;

    // error latch indexes
    localparam int E_PAR    = 0;
    localparam int E_CHK    = 1;

endpackage

// File: rtl/sysctl_bus_fsm.sv
module sysctl_bus_fsm
    import sysctl_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0061
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_cs,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic              wr_pulse,
    output logic              rd_sel
);

    bus_state_e state_q, state_d;
    logic       hit;

    assign hit = io_cs && (io_addr == PORT_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (hit && io_wr)      state_d = BUS_WRITE;
                else if (hit && io_rd) state_d = BUS_READ;
            end
            BUS_WRITE: if (!io_wr) state_d = BUS_IDLE;
            BUS_READ:  if (!io_rd) state_d = BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        wr_pulse = 1'b0;
        unique case (state_q)
            BUS_IDLE:  wr_pulse = hit && io_wr;
            BUS_WRITE: wr_pulse = 1'b0;
            BUS_READ:  wr_pulse = 1'b0;
            default:   wr_pulse = 1'b0;
        endcase
        rd_sel = hit && io_rd;
    end

    // R3: a commit is never followed by another commit on the next edge
    p_single_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse)
        else $error("R3 commit repeated");

    // R1: no commit without a decoded hit
    p_decode_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_cs && io_addr == PORT_ADDR) |-> !wr_pulse)
        else $error("R1 undecoded commit");

endmodule

// File: rtl/sysctl_err_latch.sv
module sysctl_err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic en_next,
    input  logic err_i,
    output logic flag_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_o <= 1'b0;
        else if (!en_next) flag_o <= 1'b0;
        else if (err_i)    flag_o <= 1'b1;
    end

    // R8: a disabled latch reads 0 on the next edge
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_next |=> !flag_o)
        else $error("R8 latch not cleared");

    // R6: an enabled error is captured
    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_next && err_i) |=> flag_o)
        else $error("R6 error not captured");

    // R6: a set latch stays set while enabled
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && en_next) |=> flag_o)
        else $error("R6 latch dropped");

endmodule

// File: rtl/sysctl_refresh_tog.sv
module sysctl_refresh_tog (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic tog_o
);

    logic req_q;
    logic req_rise;

    assign req_rise = req_i && !req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            tog_o <= 1'b0;
        end else begin
            req_q <= req_i;
            if (req_rise) tog_o <= !tog_o;
        end
    end

    // R5: a held request flips the toggle at most once
    p_held_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && $past(req_i)) |=> $stable(tog_o))
        else $error("R5 toggle on held request");

    // R5: the toggle flips after a new request
    p_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_rise |=> (tog_o != $past(tog_o)))
        else $error("R5 toggle missed");

endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0061
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_cs,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              tmr2_out_i,
    input  logic              refresh_req_i,
    input  logic              parity_err_i,
    input  logic              chan_err_i,
    output logic              tmr2_gate_o,
    output logic              spkr_o,
    output logic              nmi_req_o
);

    logic            wr_pulse;
    logic            rd_sel;
    logic [EN_W-1:0] en_q;
    logic [EN_W-1:0] en_d;
    logic [N_ERR-1:0] err_in;
    logic [N_ERR-1:0] err_en;
    logic [N_ERR-1:0] err_flag;
    logic            tog;
    logic            unused_hi;

    assign unused_hi = ^io_wdata[DATA_W-1:EN_W];

    sysctl_bus_fsm #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_cs    (io_cs),
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .wr_pulse (wr_pulse),
        .rd_sel   (rd_sel)
    );

    assign en_d = wr_pulse ? io_wdata[EN_W-1:0] : en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign err_in[E_PAR] = parity_err_i;
    assign err_in[E_CHK] = chan_err_i;
    assign err_en[E_PAR] = en_d[B_PAR_EN];
    assign err_en[E_CHK] = en_d[B_CHK_EN];

    for (genvar g = 0; g < N_ERR; g++) begin : g_err
        sysctl_err_latch u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_next (err_en[g]),
            .err_i   (err_in[g]),
            .flag_o  (err_flag[g])
        );
    end

    sysctl_refresh_tog u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (refresh_req_i),
        .tog_o (tog)
    );

    always_comb begin
        io_rdata = '0;
        if (rd_sel)
            io_rdata = {err_flag[E_PAR], err_flag[E_CHK], tmr2_out_i, tog, en_q};
    end

    assign tmr2_gate_o = en_q[B_GATE];
    assign spkr_o      = tmr2_out_i && en_q[B_SPKR];
    assign nmi_req_o   = |err_flag;

    // R4: speaker is never driven while the timer output is low
    p_spkr_needs_tmr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spkr_o |-> tmr2_out_i)
        else $error("R4 speaker without timer");

    // R2: stored enables change only on a commit
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |=> $stable(en_q))
        else $error("R2 enables changed without write");

    // R9: NMI request follows the latches
    p_nmi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req_o |-> (err_flag != '0))
        else $error("R9 spurious NMI");

endmodule

// File: tb/sysctl_port_bench.sv
module sysctl_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_cs = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic        tmr2_out_i = 1'b0;
    logic        refresh_req_i = 1'b0;
    logic        parity_err_i = 1'b0;
    logic        chan_err_i = 1'b0;
    logic        tmr2_gate_o;
    logic        spkr_o;
    logic        nmi_req_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    // bench model
    logic [3:0] m_en = 4'h0;
    logic       m_tog = 1'b0;
    logic       m_par = 1'b0;
    logic       m_chk = 1'b0;

    always #5 clk = ~clk;

    sysctl_port u_sysctl_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .io_cs         (io_cs),
        .io_addr       (io_addr),
        .io_rd         (io_rd),
        .io_wr         (io_wr),
        .io_wdata      (io_wdata),
        .io_rdata      (io_rdata),
        .tmr2_out_i    (tmr2_out_i),
        .refresh_req_i (refresh_req_i),
        .parity_err_i  (parity_err_i),
        .chan_err_i    (chan_err_i),
        .tmr2_gate_o   (tmr2_gate_o),
        .spkr_o        (spkr_o),
        .nmi_req_o     (nmi_req_o)
    );

    function automatic logic [7:0] model_byte();
        return {m_par, m_chk, tmr2_out_i, m_tog, m_en};
    endfunction

    // monitor: pops expected read data when a read is on the bus
    always @(negedge clk) begin
        if (io_rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (io_rdata !== e) begin
                failures++;
                $display("FAIL %s read got=%02h exp=%02h", t, io_rdata, e);
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string t);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s got=%0b exp=%0b", t, act, exp);
        end
    endtask

    task automatic bus_read(input logic cs, input logic [15:0] a,
                            input logic [7:0] e, input string t);
        @(posedge clk); #1;
        io_cs = cs; io_addr = a; io_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        io_rd = 1'b0; io_cs = 1'b0;
    endtask

    task automatic rd_model(input string t);
        bus_read(1'b1, 16'h0061, model_byte(), t);
    endtask

    // write with optional error inputs raised in the commit cycle
    task automatic bus_write_err(input logic cs, input logic [15:0] a,
                                 input logic [7:0] d, input logic pe, input logic ce);
        @(posedge clk); #1;
        io_cs = cs; io_addr = a; io_wdata = d; io_wr = 1'b1;
        parity_err_i = pe; chan_err_i = ce;
        @(posedge clk); #1;
        io_wr = 1'b0; io_cs = 1'b0; parity_err_i = 1'b0; chan_err_i = 1'b0;
        if (cs && a == 16'h0061) begin
            m_en = d[3:0];
            if (!m_en[2]) m_par = 1'b0; else if (pe) m_par = 1'b1;
            if (!m_en[3]) m_chk = 1'b0; else if (ce) m_chk = 1'b1;
        end
    endtask

    task automatic bus_write(input logic [7:0] d);
        bus_write_err(1'b1, 16'h0061, d, 1'b0, 1'b0);
    endtask

    task automatic pulse_err(input logic pe, input logic ce);
        @(posedge clk); #1;
        parity_err_i = pe; chan_err_i = ce;
        @(posedge clk); #1;
        parity_err_i = 1'b0; chan_err_i = 1'b0;
        if (pe && m_en[2]) m_par = 1'b1;
        if (ce && m_en[3]) m_chk = 1'b1;
    endtask

    task automatic refresh(input int len);
        @(posedge clk); #1;
        refresh_req_i = 1'b1;
        repeat (len) @(posedge clk);
        #1 refresh_req_i = 1'b0;
        m_tog = !m_tog;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        bus_read(1'b1, 16'h0061, 8'h00, "R10 reset value");
        #1;
        chk(tmr2_gate_o, 1'b0, "R10 gate after reset");
        chk(spkr_o, 1'b0, "R10 speaker after reset");
        chk(nmi_req_o, 1'b0, "R10 nmi after reset");

        // R2 low bits stored, high bits ignored
        bus_write(8'hFF);
        rd_model("R2 write FF readback");
        bus_write(8'hA6);
        rd_model("R2 write A6 readback");
        bus_write(8'h00);

        // R1 decode
        bus_write_err(1'b1, 16'h0062, 8'h05, 1'b0, 1'b0);
        rd_model("R1 wrong address write ignored");
        bus_write_err(1'b0, 16'h0061, 8'h05, 1'b0, 1'b0);
        rd_model("R1 no chip select write ignored");
        bus_read(1'b1, 16'h0062, 8'h00, "R1 wrong address read");
        bus_read(1'b0, 16'h0061, 8'h00, "R1 unselected read");

        // R4 timer, speaker, gate
        bus_write(8'h03);
        tmr2_out_i = 1'b1;
        rd_model("R4 timer level bit5");
        chk(spkr_o, 1'b1, "R4 speaker on");
        chk(tmr2_gate_o, 1'b1, "R4 gate on");
        bus_write(8'h01);
        #1;
        chk(spkr_o, 1'b0, "R4 speaker masked");
        chk(tmr2_gate_o, 1'b1, "R4 gate still on");
        tmr2_out_i = 1'b0;
        rd_model("R4 timer low");

        // R3 held strobe
        @(posedge clk); #1;
        io_cs = 1'b1; io_addr = 16'h0061; io_wdata = 8'h02; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wdata = 8'h0C;
        repeat (2) @(posedge clk);
        #1 io_wr = 1'b0; io_cs = 1'b0;
        m_en = 4'h2;
        rd_model("R3 held strobe single commit");

        // R5 refresh toggle
        refresh(1);
        rd_model("R5 toggle after one request");
        refresh(4);
        rd_model("R5 held request toggles once");
        refresh(2);
        rd_model("R5 third request");

        // R6 parity latch
        bus_write(8'h00);
        pulse_err(1'b1, 1'b0);
        rd_model("R6 parity ignored while disabled");
        chk(nmi_req_o, 1'b0, "R9 no nmi when disabled");
        bus_write(8'h04);
        pulse_err(1'b1, 1'b0);
        rd_model("R6 parity latched");
        chk(nmi_req_o, 1'b1, "R9 nmi from parity");
        repeat (3) @(posedge clk);
        rd_model("R6 parity sticky");
        bus_write(8'h00);
        rd_model("R8 parity cleared by write");
        chk(nmi_req_o, 1'b0, "R9 nmi clears");

        // R7 channel latch
        pulse_err(1'b0, 1'b1);
        rd_model("R7 channel ignored while disabled");
        bus_write(8'h08);
        pulse_err(1'b0, 1'b1);
        rd_model("R7 channel latched");
        chk(nmi_req_o, 1'b1, "R9 nmi from channel");
        bus_write(8'h0C);
        pulse_err(1'b1, 1'b0);
        rd_model("R6 both latches set");

        // R8 collisions of write and error in one cycle
        bus_write_err(1'b1, 16'h0061, 8'h00, 1'b1, 1'b1);
        rd_model("R8 clear wins over error");
        chk(nmi_req_o, 1'b0, "R8 nmi low after clear");
        bus_write_err(1'b1, 16'h0061, 8'h04, 1'b1, 1'b1);
        rd_model("R8 enable and error same edge");
        chk(nmi_req_o, 1'b1, "R9 nmi after same-edge set");

        // R10 reset mid-run
        bus_write(8'h0F);
        pulse_err(1'b1, 1'b1);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        m_en = 4'h0; m_par = 1'b0; m_chk = 1'b0; m_tog = 1'b0;
        bus_read(1'b1, 16'h0061, 8'h00, "R10 reset clears all");
        #1;
        chk(nmi_req_o, 1'b0, "R10 nmi after reset");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule